// File: doc/BRIEF.md
# SCSI Host Adapter PCI Configuration Registers

This block holds the type-0 configuration header registers of a PCI SCSI host adapter that software actually programs. These are the command byte, an I/O base register, a base register for the memory-mapped register window, an optional on-chip RAM base register, an expansion ROM base register and the interrupt line byte. The configuration port moves one byte per access. It has a byte address, a write strobe, write data and a combinational read-data path.

From the stored values the block derives the base address and a decode enable for three memory windows: the register window, the RAM window and the ROM window. Address decoders elsewhere in the adapter use these outputs. Two strap inputs shape the header. `ram_fitted` is low on low-end variants, and then the RAM base register does not exist. `rom_fitted` is low when no boot ROM is attached, and then the expansion ROM register is frozen.

Top module: `hba_cfg_space`

## Requirements
- R1: After reset the command byte (offset 0x04) reads 0x03. I/O BAR byte 0x10 reads 0x01. Every other BAR byte, the interrupt line (0x3C) and all window enables read 0.
- R2: Only command bits [2:0] are writable; bits [7:3] read 0. Bit 0 drives `io_space_en` and bit 1 drives `mem_space_en`.
- R3: In the I/O BAR (0x10–0x13), bit 0 always reads 1 and bits [7:1] of byte 0x10 read 0. Bytes 0x11–0x13 read back what was written.
- R4: The register-window BAR (0x14–0x17) stores the written value ANDed with 0xFFFCF000. It reads back that masked value, and `reg_win_base` equals it.
- R5: The RAM BAR (0x18–0x1B) uses the same 0xFFFCF000 mask, and byte 0x18 always reads 0. With `ram_fitted` low, bytes 0x18–0x1B read 0, writes to them leave the stored value unchanged, and `ram_win_en` is 0.
- R6: `reg_win_en` (and `ram_win_en` when fitted) is 1 exactly when command bit 1 is set and the window's base is nonzero. Clearing bit 1 closes both windows on the next cycle.
- R7: Expansion ROM byte 0x30 reads only bit 0, the ROM enable; bits [7:1] read 0. Bytes 0x31–0x33 read the stored value masked with 0xFFFCF000, and `rom_win_base` is the stored value ANDed with 0xFFFCF000.
- R8: With `rom_fitted` low, writes to 0x30–0x33 are ignored and `rom_win_en` is 0.
- R9: `rom_win_en` is 1 only when `rom_fitted` is high, the ROM enable bit is 1 and the ROM base is nonzero. It does not depend on the command register.
- R10: The interrupt line byte at 0x3C reads back what was written and drives `irq_line`.
- R11: Offsets outside the listed registers read 0, and writes to them change nothing.
- R12: A synchronous active-high reset returns every register and enable to its R1 value, even after the registers have been programmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ram_fitted | input | 1 | Variant strap: 1 when the on-chip RAM BAR exists |
| rom_fitted | input | 1 | Strap: 1 when a boot ROM is attached |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_we | input | 1 | Write strobe for the addressed byte |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr` (combinational) |
| io_space_en | output | 1 | Command bit 0 |
| mem_space_en | output | 1 | Command bit 1 |
| reg_win_en | output | 1 | Register-window decode enable |
| reg_win_base | output | 32 | Register-window base address |
| ram_win_en | output | 1 | RAM-window decode enable |
| ram_win_base | output | 32 | RAM-window base address (0 when not fitted) |
| rom_win_en | output | 1 | ROM-window decode enable |
| rom_win_base | output | 32 | ROM-window base address |
| irq_line | output | 8 | Interrupt line register |

## Verification
The bench builds the block with its default parameters. These are a window mask of 0xFFFCF000, an I/O mask of 0xFFFFFF00 and three writable command bits. With these values, the hole in bits 16–17 of each memory window and the forced-zero low byte show up directly in the readback of all-ones writes. The straps are bench inputs, so both settings of `ram_fitted` and `rom_fitted` are tested. This includes frozen registers whose contents are read back after the strap is raised again.

// File: rtl/hba_cfg_pkg.sv
package hba_cfg_pkg;

    localparam int CFG_AW = 8;
    typedef logic [CFG_AW-1:0] cfg_addr_t;

    // Header offsets; only the 4-byte slot of each BAR is decoded here
    localparam cfg_addr_t OFF_CMD      = 8'h04;
    localparam cfg_addr_t OFF_IO_BAR   = 8'h10;
    localparam cfg_addr_t OFF_REG_BAR  = 8'h14;
    localparam cfg_addr_t OFF_RAM_BAR  = 8'h18;
    localparam cfg_addr_t OFF_ROM_BAR  = 8'h30;
    localparam cfg_addr_t OFF_IRQ_LINE = 8'h3C;

    typedef struct packed {
        logic [7:0]  cmd;
        logic [31:0] io_bar;
        logic [31:0] reg_bar;
        logic [31:0] ram_bar;
        logic [31:0] rom_bar;
        logic [7:0]  irq;
    } cfg_view_t;

    function automatic logic in_slot(cfg_addr_t a, cfg_addr_t base);
        return a[CFG_AW-1:2] == base[CFG_AW-1:2];
    endfunction

    function automatic logic [7:0] lane_of(logic [31:0] w, logic [1:0] idx);
        return w[8*idx +: 8];
    endfunction

endpackage

// File: rtl/cfg_bar_reg.sv
module cfg_bar_reg
    import hba_cfg_pkg::*;
#(
    parameter cfg_addr_t   SLOT  = 8'h10,
    parameter logic [31:0] WMASK = 32'hFFFF_FFFF,
    parameter logic [31:0] FIXED = 32'h0000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        allow,
    input  cfg_addr_t   addr,
    input  logic        we,
    input  logic [7:0]  wdata,
    output logic [31:0] value
);

    localparam int LANES = 4;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [7:0] lane_q;
        always_ff @(posedge clk) begin
            if (rst)
                lane_q <= '0;
            else if (we && allow && addr == (SLOT + cfg_addr_t'(b)))
                lane_q <= wdata & WMASK[8*b +: 8];
        end
        assign value[8*b +: 8] = lane_q | FIXED[8*b +: 8];
    end

    AST_BAR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !allow |=> $stable(value)); // R5 R8

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
    import hba_cfg_pkg::*;
(
    input  cfg_addr_t  addr,
    input  cfg_view_t  view,
    input  logic       ram_fitted,
    output logic [7:0] rdata
);

    always_comb begin
        rdata = 8'h00;
        if (addr == OFF_CMD)
            rdata = view.cmd;
        else if (in_slot(addr, OFF_IO_BAR))
            rdata = lane_of(view.io_bar, addr[1:0]);
        else if (in_slot(addr, OFF_REG_BAR))
            rdata = lane_of(view.reg_bar, addr[1:0]);
        else if (in_slot(addr, OFF_RAM_BAR))
            rdata = ram_fitted ? lane_of(view.ram_bar, addr[1:0]) : 8'h00;
        else if (in_slot(addr, OFF_ROM_BAR))
            rdata = (addr[1:0] == 2'd0) ? {7'd0, view.rom_bar[0]}
                                        : lane_of(view.rom_bar, addr[1:0]);
        else if (addr == OFF_IRQ_LINE)
            rdata = view.irq;
    end

endmodule

// File: rtl/hba_cfg_space.sv
module hba_cfg_space
    import hba_cfg_pkg::*;
#(
    parameter logic [31:0] WIN_MASK  = 32'hFFFC_F000,
    parameter logic [31:0] IO_MASK   = 32'hFFFF_FF00,
    parameter logic [7:0]  CMD_WMASK = 8'h07,
    parameter logic [7:0]  CMD_RESET = 8'h03
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ram_fitted,
    input  logic        rom_fitted,
    input  logic [7:0]  cfg_addr,
    input  logic        cfg_we,
    input  logic [7:0]  cfg_wdata,
    output logic [7:0]  cfg_rdata,
    output logic        io_space_en,
    output logic        mem_space_en,
    output logic        reg_win_en,
    output logic [31:0] reg_win_base,
    output logic        ram_win_en,
    output logic [31:0] ram_win_base,
    output logic        rom_win_en,
    output logic [31:0] rom_win_base,
    output logic [7:0]  irq_line
);

    localparam logic [31:0] ROM_WMASK = WIN_MASK | 32'h1;
    localparam int MEM_BIT = 1;

    logic [7:0] cmd_q;
    logic [7:0] irq_q;
    cfg_view_t  view;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= CMD_RESET;
            irq_q <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == OFF_CMD)      cmd_q <= cfg_wdata & CMD_WMASK;
            if (cfg_addr == OFF_IRQ_LINE) irq_q <= cfg_wdata;
        end
    end

    cfg_bar_reg #(.SLOT(OFF_IO_BAR), .WMASK(IO_MASK), .FIXED(32'h1)) u_io_bar (
        .clk(clk), .rst(rst), .allow(1'b1), .addr(cfg_addr), .we(cfg_we),
        .wdata(cfg_wdata), .value(view.io_bar));

    cfg_bar_reg #(.SLOT(OFF_REG_BAR), .WMASK(WIN_MASK), .FIXED(32'h0)) u_reg_bar (
        .clk(clk), .rst(rst), .allow(1'b1), .addr(cfg_addr), .we(cfg_we),
        .wdata(cfg_wdata), .value(view.reg_bar));

    cfg_bar_reg #(.SLOT(OFF_RAM_BAR), .WMASK(WIN_MASK), .FIXED(32'h0)) u_ram_bar (
        .clk(clk), .rst(rst), .allow(ram_fitted), .addr(cfg_addr), .we(cfg_we),
        .wdata(cfg_wdata), .value(view.ram_bar));

    cfg_bar_reg #(.SLOT(OFF_ROM_BAR), .WMASK(ROM_WMASK), .FIXED(32'h0)) u_rom_bar (
        .clk(clk), .rst(rst), .allow(rom_fitted), .addr(cfg_addr), .we(cfg_we),
        .wdata(cfg_wdata), .value(view.rom_bar));

    assign view.cmd = cmd_q;
    assign view.irq = irq_q;

    cfg_read_mux u_rd_mux (
        .addr(cfg_addr), .view(view), .ram_fitted(ram_fitted), .rdata(cfg_rdata));

    assign io_space_en  = cmd_q[0];
    assign mem_space_en = cmd_q[MEM_BIT];
    assign irq_line     = irq_q;

    assign reg_win_base = view.reg_bar & WIN_MASK;
    assign reg_win_en   = cmd_q[MEM_BIT] && (reg_win_base != '0);

    assign ram_win_base = ram_fitted ? (view.ram_bar & WIN_MASK) : '0;
    assign ram_win_en   = ram_fitted && cmd_q[MEM_BIT] && (ram_win_base != '0);

    assign rom_win_base = view.rom_bar & WIN_MASK;
    assign rom_win_en   = rom_fitted && view.rom_bar[0] && (rom_win_base != '0);

    AST_CMD_RESET: assert property (@(posedge clk)
        rst |=> (cfg_addr != OFF_CMD) || (cfg_rdata == CMD_RESET)); // R1

    AST_MEM_OFF_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == OFF_CMD && !cfg_wdata[MEM_BIT])
        |=> (!reg_win_en && !ram_win_en)); // R6

    AST_ROM_OFF_CLOSES: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == OFF_ROM_BAR && !cfg_wdata[0])
        |=> !rom_win_en); // R9

    AST_NO_RAM_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !ram_fitted |-> !ram_win_en); // R5

    AST_ROM_LOW_BYTE: assert property (@(posedge clk) disable iff (rst)
        (cfg_addr == OFF_ROM_BAR) |-> (cfg_rdata[7:1] == 7'd0)); // R7

endmodule

// File: tb/hba_cfg_space_bench.sv
module hba_cfg_space_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ram_fitted = 1'b1;
    logic        rom_fitted = 1'b1;
    logic [7:0]  cfg_addr = 8'h00;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = 8'h00;
    logic [7:0]  cfg_rdata;
    logic        io_space_en, mem_space_en;
    logic        reg_win_en, ram_win_en, rom_win_en;
    logic [31:0] reg_win_base, ram_win_base, rom_win_base;
    logic [7:0]  irq_line;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    hba_cfg_space u_hba_cfg_space (
        .clk(clk), .rst(rst), .ram_fitted(ram_fitted), .rom_fitted(rom_fitted),
        .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .io_space_en(io_space_en),
        .mem_space_en(mem_space_en), .reg_win_en(reg_win_en),
        .reg_win_base(reg_win_base), .ram_win_en(ram_win_en),
        .ram_win_base(ram_win_base), .rom_win_en(rom_win_en),
        .rom_win_base(rom_win_base), .irq_line(irq_line));

    typedef struct packed {
        logic [3:0] req;
        logic [7:0] addr;
        logic [7:0] wdata;
        logic [7:0] expect_rd;
    } vec_t;

    localparam int NVEC = 19;
    localparam vec_t VECS [NVEC] = '{
        '{4'd2,  8'h04, 8'hFF, 8'h07},  // R2 upper command bits dropped
        '{4'd2,  8'h04, 8'h01, 8'h01},  // R2
        '{4'd3,  8'h10, 8'hFE, 8'h01},  // R3 I/O indicator forced
        '{4'd3,  8'h11, 8'h12, 8'h12},  // R3
        '{4'd4,  8'h14, 8'hFF, 8'h00},  // R4 low byte masked
        '{4'd4,  8'h15, 8'hFF, 8'hF0},  // R4
        '{4'd4,  8'h16, 8'hFF, 8'hFC},  // R4 hole in bits 17:16
        '{4'd4,  8'h17, 8'hA5, 8'hA5},  // R4
        '{4'd5,  8'h18, 8'hFF, 8'h00},  // R5 byte 0x18 reads zero
        '{4'd5,  8'h19, 8'h3F, 8'h30},  // R5
        '{4'd5,  8'h1A, 8'h07, 8'h04},  // R5
        '{4'd5,  8'h1B, 8'h80, 8'h80},  // R5
        '{4'd7,  8'h30, 8'hFF, 8'h01},  // R7 only enable bit
        '{4'd7,  8'h31, 8'hFF, 8'hF0},  // R7
        '{4'd7,  8'h32, 8'h03, 8'h00},  // R7
        '{4'd7,  8'h33, 8'hC0, 8'hC0},  // R7
        '{4'd10, 8'h3C, 8'h0B, 8'h0B},  // R10
        '{4'd11, 8'h08, 8'h55, 8'h00},  // R11 unlisted offset
        '{4'd11, 8'h3D, 8'h55, 8'h00}   // R11
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_addr = a; cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic [7:0] a, output logic [7:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic pulse_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        logic [7:0] rd;
        repeat (2) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        cfg_rd(8'h04, rd); chk("R1 cmd", {24'd0, rd}, 32'h03);
        cfg_rd(8'h10, rd); chk("R1 io bar", {24'd0, rd}, 32'h01);
        cfg_rd(8'h17, rd); chk("R1 reg bar", {24'd0, rd}, 32'h00);
        cfg_rd(8'h3C, rd); chk("R1 irq", {24'd0, rd}, 32'h00);
        chk("R1 win enables", {29'd0, reg_win_en, ram_win_en, rom_win_en}, 32'd0);
        chk("R2 space enables", {30'd0, mem_space_en, io_space_en}, 32'd3);

        for (int i = 0; i < NVEC; i++) begin
            cfg_wr(VECS[i].addr, VECS[i].wdata);
            cfg_rd(VECS[i].addr, rd);
            checks++;
            if (rd !== VECS[i].expect_rd) begin
                fails++;
                $display("FAIL R%0d vec %0d addr 0x%02h: actual 0x%02h expected 0x%02h",
                         VECS[i].req, i, VECS[i].addr, rd, VECS[i].expect_rd);
            end
        end

        // R6 memory space off: windows closed despite nonzero bases
        chk("R6 closed", {30'd0, reg_win_en, ram_win_en}, 32'd0);
        chk("R2 mem bit off", {31'd0, mem_space_en}, 32'd0);
        chk("R10 irq out", {24'd0, irq_line}, 32'h0B);
        cfg_wr(8'h04, 8'h02);
        chk("R6 open", {30'd0, reg_win_en, ram_win_en}, 32'd3);
        chk("R4 reg base", reg_win_base, 32'hA5FC_F000);
        chk("R5 ram base", ram_win_base, 32'h8004_3000);

        // R7 / R9 ROM window
        chk("R7 rom base", rom_win_base, 32'hC000_F000);
        chk("R9 rom open", {31'd0, rom_win_en}, 32'd1);
        cfg_wr(8'h30, 8'h00);
        chk("R9 rom disabled", {31'd0, rom_win_en}, 32'd0);
        chk("R7 base kept", rom_win_base, 32'hC000_F000);
        cfg_wr(8'h31, 8'h00); cfg_wr(8'h32, 8'h00); cfg_wr(8'h33, 8'h00);
        cfg_wr(8'h30, 8'h01);
        chk("R9 zero base", {31'd0, rom_win_en}, 32'd0);

        // R6 zero register base with memory enabled
        cfg_wr(8'h15, 8'h00); cfg_wr(8'h16, 8'h00); cfg_wr(8'h17, 8'h00);
        chk("R6 zero base", {31'd0, reg_win_en}, 32'd0);
        chk("R6 ram still open", {31'd0, ram_win_en}, 32'd1);

        // R5 RAM BAR hidden on a low-end variant
        ram_fitted = 1'b0;
        #1;
        chk("R5 ram en off", {31'd0, ram_win_en}, 32'd0);
        chk("R5 ram base zero", ram_win_base, 32'd0);
        cfg_rd(8'h1B, rd); chk("R5 reads zero", {24'd0, rd}, 32'h00);
        cfg_wr(8'h1B, 8'h11);
        ram_fitted = 1'b1;
        #1;
        cfg_rd(8'h1B, rd); chk("R5 write ignored", {24'd0, rd}, 32'h80);

        // R12 reset after programming
        pulse_reset();
        cfg_rd(8'h04, rd); chk("R12 cmd", {24'd0, rd}, 32'h03);
        cfg_rd(8'h10, rd); chk("R12 io", {24'd0, rd}, 32'h01);
        cfg_rd(8'h11, rd); chk("R12 io hi", {24'd0, rd}, 32'h00);
        cfg_rd(8'h3C, rd); chk("R12 irq", {24'd0, rd}, 32'h00);
        chk("R12 enables", {29'd0, reg_win_en, ram_win_en, rom_win_en}, 32'd0);
        chk("R12 ram base", ram_win_base, 32'd0);

        // R8 ROM BAR frozen without a ROM
        rom_fitted = 1'b0;
        cfg_wr(8'h33, 8'h40);
        cfg_wr(8'h30, 8'h01);
        chk("R8 rom en", {31'd0, rom_win_en}, 32'd0);
        rom_fitted = 1'b1;
        #1;
        cfg_rd(8'h33, rd); chk("R8 hi ignored", {24'd0, rd}, 32'h00);
        cfg_rd(8'h30, rd); chk("R8 enable ignored", {24'd0, rd}, 32'h00);
        chk("R8 rom still closed", {31'd0, rom_win_en}, 32'd0);

        summary();
    end

endmodule